// File: doc/BRIEF.md
# SPI DMA Request Generator

This block sits beside the FIFOs of an SPI controller and decides when to ask a DMA engine for service. For the transmit side it raises a request while the transmit FIFO has drained to a programmed level or lower. For the receive side it raises a request once the receive FIFO holds more words than a programmed level. Each direction has its own enable bit and its own level, so either side can run on DMA alone.

A request drops in the cycle after its acknowledge and is then worked out again from the live FIFO levels. This lets an engine that has just moved a burst see the request again only if the FIFO still meets the condition. Both requests are held low at once whenever the controller is disabled.

The block also suggests burst sizes. The receive burst is the largest power of two up to 8 that divides the frame count, so the last burst of a transfer is never partial. The receive level should be programmed to that value minus one. The transmit burst is a fixed quarter of the FIFO depth.

Top module: `spi_dma_req_gen`

## Requirements
- R1: While reset is asserted and until the first clock edge after release, `tx_req` and `rx_req` are both low.
- R2: With `ctl_en` high and `dma_ctl[1]` set, `tx_req` is high in the cycle after a clock edge at which `tx_fill <= tx_level`, and low in the cycle after an edge at which `tx_fill > tx_level`.
- R3: With `dma_ctl[1]` clear, `tx_req` stays low for every FIFO level and threshold, and `rx_req` follows R4 unchanged.
- R4: With `ctl_en` high and `dma_ctl[0]` set, `rx_req` is high in the cycle after a clock edge at which `rx_fill >= rx_level + 1`, and low otherwise.
- R5: With `dma_ctl[0]` clear, `rx_req` stays low for every FIFO level and threshold, and `tx_req` follows R2 unchanged.
- R6: A request sampled with its acknowledge high at a clock edge is low in the following cycle. It is then recomputed, and is high one cycle later if its condition still holds and the acknowledge has been released.
- R7: When `ctl_en` is low, `tx_req` and `rx_req` are low in the same cycle, with no clock edge needed.
- R8: `rx_burst_len` equals 1 if bit 0 of `frame_cnt` is set. Otherwise it equals 2 if bit 1 is set, otherwise 4 if bit 2 is set, and otherwise 8.
- R9: `tx_burst_len` equals FIFO depth divided by four.
- R10: An acknowledge on one direction has no effect on the request of the other direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ctl_en | input | 1 | Controller enable; low forces both requests low |
| dma_ctl | input | 2 | Bit 0 enables receive requests, bit 1 enables transmit requests |
| tx_level | input | LW | Transmit data level; request while fill is at or below it |
| rx_level | input | LW | Receive data level (burst minus one); request while fill exceeds it |
| tx_fill | input | LW | Current transmit FIFO occupancy |
| rx_fill | input | LW | Current receive FIFO occupancy |
| tx_ack | input | 1 | Transmit request acknowledge from the DMA engine |
| rx_ack | input | 1 | Receive request acknowledge from the DMA engine |
| frame_cnt | input | CW | Number of frames in the transfer, used for the burst hint |
| tx_req | output | 1 | Transmit DMA request |
| rx_req | output | 1 | Receive DMA request |
| rx_burst_len | output | 4 | Suggested receive burst: 1, 2, 4 or 8 |
| tx_burst_len | output | LW | Transmit burst: FIFO depth divided by four |

## Verification
The hardest case to reach is an acknowledge that lands while the level condition still holds, so that the request must drop for exactly one cycle and then come back. A bare level sweep never shows this. The stimulus therefore holds the FIFO levels steady in the asserting region and pulses one acknowledge for a single cycle. It then samples that request in the cycle of the drop and in the cycle after. It also samples the other direction's request in the same cycles to show it is left alone. The levels and thresholds themselves are swept exhaustively under all four enable combinations.

// File: rtl/spidreq_pkg.sv
package spidreq_pkg;
  // Comparison sense of one request unit
  typedef enum logic {
    CMP_AT_OR_BELOW = 1'b0,  // drain-side: fill <= level
    CMP_ABOVE       = 1'b1   // fill-side: fill >= level + 1
  } cmp_mode_e;

  localparam int unsigned BURST_W = 4;
endpackage

// File: rtl/spidreq_rst_sync.sv
module spidreq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/spidreq_unit.sv
module spidreq_unit
  import spidreq_pkg::*;
#(
  parameter int unsigned LW   = 4,
  parameter cmp_mode_e   MODE = CMP_AT_OR_BELOW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_en,
  input  logic          dir_en,
  input  logic [LW-1:0] fill,
  input  logic [LW-1:0] level,
  input  logic          ack,
  output logic          req_q
);
  logic hit;
  logic req_d;
  logic req_ce;

  generate
    if (MODE == CMP_AT_OR_BELOW) begin : g_drain
      assign hit = (fill <= level);
    end else begin : g_fill
      // fill >= level + 1 without overflow
      assign hit = ({1'b0, fill} >= ({1'b0, level} + {{LW{1'b0}}, 1'b1}));
    end
  endgenerate

  always_comb begin
    req_ce = 1'b1;
    req_d  = ctl_en && dir_en && hit && !ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else if (req_ce) begin
      req_q <= req_d;
    end
  end

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !req_q);  // R6

  AST_DIR_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_en |=> !req_q);  // R3

  AST_CTL_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> !req_q);  // R7

  AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(dir_en && ctl_en));  // R4
endmodule

// File: rtl/spidreq_burst_pick.sv
module spidreq_burst_pick
  import spidreq_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic [CW-1:0]      frame_cnt,
  output logic [BURST_W-1:0] burst_len
);
  always_comb begin
    if (frame_cnt[0])      burst_len = 4'd1;
    else if (frame_cnt[1]) burst_len = 4'd2;
    else if (frame_cnt[2]) burst_len = 4'd4;
    else                   burst_len = 4'd8;
  end

  always_comb begin
    AST_BURST_ONEHOT: assert ($countones(burst_len) == 1);  // R8
  end
endmodule

// File: rtl/spi_dma_req_gen.sv
module spi_dma_req_gen
  import spidreq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CW    = 16,
  parameter int unsigned LW    = $clog2(DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_en,
  input  logic [1:0]          dma_ctl,
  input  logic [LW-1:0]       tx_level,
  input  logic [LW-1:0]       rx_level,
  input  logic [LW-1:0]       tx_fill,
  input  logic [LW-1:0]       rx_fill,
  input  logic                tx_ack,
  input  logic                rx_ack,
  input  logic [CW-1:0]       frame_cnt,
  output logic                tx_req,
  output logic                rx_req,
  output logic [BURST_W-1:0]  rx_burst_len,
  output logic [LW-1:0]       tx_burst_len
);
  localparam int unsigned RX_BIT   = 0;
  localparam int unsigned TX_BIT   = 1;
  localparam int unsigned TX_BURST = DEPTH / 4;

  logic rst_n_s;
  logic tx_req_q;
  logic rx_req_q;

  spidreq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  spidreq_unit #(.LW(LW), .MODE(CMP_AT_OR_BELOW)) u_tx (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .ctl_en (ctl_en),
    .dir_en (dma_ctl[TX_BIT]),
    .fill   (tx_fill),
    .level  (tx_level),
    .ack    (tx_ack),
    .req_q  (tx_req_q)
  );

  spidreq_unit #(.LW(LW), .MODE(CMP_ABOVE)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .ctl_en (ctl_en),
    .dir_en (dma_ctl[RX_BIT]),
    .fill   (rx_fill),
    .level  (rx_level),
    .ack    (rx_ack),
    .req_q  (rx_req_q)
  );

  spidreq_burst_pick #(.CW(CW)) u_burst (
    .frame_cnt (frame_cnt),
    .burst_len (rx_burst_len)
  );

  assign tx_req       = tx_req_q && ctl_en;
  assign rx_req       = rx_req_q && ctl_en;
  assign tx_burst_len = LW'(TX_BURST);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n_s |=> !(tx_req_q || rx_req_q));  // R1

  AST_TX_ACK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rx_ack && !tx_ack && ctl_en && dma_ctl[TX_BIT] && (tx_fill <= tx_level)) |=> tx_req_q);  // R10
endmodule

// File: tb/sim_spi_dma_req_gen.sv
`timescale 1ns/1ps
module sim_spi_dma_req_gen;
  localparam int unsigned DEPTH = 8;
  localparam int unsigned CW    = 16;
  localparam int unsigned LW    = $clog2(DEPTH) + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ctl_en;
  logic [1:0]    dma_ctl;
  logic [LW-1:0] tx_level, rx_level, tx_fill, rx_fill;
  logic          tx_ack, rx_ack;
  logic [CW-1:0] frame_cnt;
  logic          tx_req, rx_req;
  logic [3:0]    rx_burst_len;
  logic [LW-1:0] tx_burst_len;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;  // 250 MHz

  spi_dma_req_gen #(.DEPTH(DEPTH), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .dma_ctl(dma_ctl),
    .tx_level(tx_level), .rx_level(rx_level), .tx_fill(tx_fill),
    .rx_fill(rx_fill), .tx_ack(tx_ack), .rx_ack(rx_ack),
    .frame_cnt(frame_cnt), .tx_req(tx_req), .rx_req(rx_req),
    .rx_burst_len(rx_burst_len), .tx_burst_len(tx_burst_len)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; ctl_en = 1'b0; dma_ctl = 2'b00;
    tx_level = '0; rx_level = '0; tx_fill = '0; rx_fill = '0;
    tx_ack = 1'b0; rx_ack = 1'b0; frame_cnt = '0;
    #1;
    chk("R1 tx_req in reset", int'(tx_req), 0);
    chk("R1 rx_req in reset", int'(rx_req), 0);
    repeat (3) step();
    ctl_en = 1'b1; dma_ctl = 2'b11;
    chk("R1 tx_req held reset", int'(tx_req), 0);
    chk("R1 rx_req held reset", int'(rx_req), 0);
    step(); rst_n = 1'b1;
    repeat (4) step();

    // R9
    chk("R9 tx burst", int'(tx_burst_len), DEPTH / 4);

    // R2 R3 R4 R5: exhaustive sweep, all enable combinations
    for (int m = 0; m < 4; m++) begin
      for (int t = 0; t < DEPTH; t++) begin
        for (int f = 0; f <= DEPTH; f++) begin
          dma_ctl = 2'(m);
          tx_level = LW'(t); rx_level = LW'(t);
          tx_fill = LW'(f);  rx_fill = LW'(DEPTH - f);
          step();
          if (m[1]) chk("R2 tx level", int'(tx_req), (f <= t) ? 1 : 0);
          else      chk("R3 tx disabled", int'(tx_req), 0);
          if (m[0]) chk("R4 rx level", int'(rx_req), ((DEPTH - f) >= t + 1) ? 1 : 0);
          else      chk("R5 rx disabled", int'(rx_req), 0);
        end
      end
    end

    // R6 R10: ack on tx while condition holds
    dma_ctl = 2'b11; tx_level = 4'd3; tx_fill = 4'd1; rx_level = 4'd1; rx_fill = 4'd5;
    step();
    chk("R6 tx pre", int'(tx_req), 1);
    tx_ack = 1'b1;
    step(); tx_ack = 1'b0;
    chk("R6 tx drop", int'(tx_req), 0);
    chk("R10 rx kept", int'(rx_req), 1);
    step();
    chk("R6 tx back", int'(tx_req), 1);
    // rx ack
    rx_ack = 1'b1;
    step(); rx_ack = 1'b0;
    chk("R6 rx drop", int'(rx_req), 0);
    chk("R10 tx kept", int'(tx_req), 1);
    step();
    chk("R6 rx back", int'(rx_req), 1);
    // ack then condition lost: stays low
    tx_ack = 1'b1;
    step(); tx_ack = 1'b0; tx_fill = 4'd7;
    chk("R6 tx drop2", int'(tx_req), 0);
    step();
    chk("R6 tx recomputed low", int'(tx_req), 0);
    tx_fill = 4'd1;
    step();

    // R7: immediate force low
    chk("R7 tx pre", int'(tx_req), 1);
    #1 ctl_en = 1'b0;
    #1;
    chk("R7 tx forced", int'(tx_req), 0);
    chk("R7 rx forced", int'(rx_req), 0);
    step();
    chk("R7 tx stays", int'(tx_req), 0);
    chk("R7 rx stays", int'(rx_req), 0);
    ctl_en = 1'b1;
    step();
    chk("R7 tx resumes", int'(tx_req), 1);

    // R8: burst pick sweep
    for (int fc = 0; fc < 300; fc++) begin
      int e;
      frame_cnt = CW'(fc);
      #1;
      e = (fc % 2 != 0) ? 1 : (fc % 4 != 0) ? 2 : (fc % 8 != 0) ? 4 : 8;
      chk("R8 burst", int'(rx_burst_len), e);
    end
    frame_cnt = 16'hFFF8; #1;
    chk("R8 burst high", int'(rx_burst_len), 8);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule